// File: doc/BRIEF.md
# RGB to YUV Colour-Space Converter

This block converts a stream of 10-bit RGB pixels into limited-range YUV. One pixel is accepted per cycle through a valid/ready handshake. Each input channel is first limited to a programmable window and then offset by a signed pre-bias. A 3x3 matrix of signed fixed-point coefficients is applied next. Each row is rounded, given a post-bias, and limited to a per-channel output window. Results appear three cycles after acceptance.

All coefficients, biases and windows live in a small register bank that is loaded through a one-cycle write port. At reset the bank holds a standard limited-range conversion table. The converter itself starts disabled. In that state pixels pass through untouched, with the same latency, so a stream can be switched between paths without retiming the consumer.

Top module: `rgb2yuv_csc`

## Requirements
- R1: While reset is asserted, out_valid is 0. After reset, in_ready is 1, the enable bit is 0, and the bank holds these defaults: Y row coefficients 0x083, 0x102, 0x032; Cb row 0x1FB5, 0x1F6C, 0x0E1; Cr row 0x0E1, 0x1F45, 0x1FDC; pre-bias 0; post-bias 0x040/0x200/0x200; input windows 0x000..0x3FF; output windows Y 0x040..0x3AC and Cb/Cr 0x040..0x3C0.
- R2: Each input channel (R, G, B) is limited to its own window. A value below lo becomes lo. Otherwise, a value above hi becomes hi.
- R3: After the input window, an 11-bit two's-complement pre-bias is added to each channel.
- R4: Coefficients are 13-bit two's complement with 9 fractional bits, and the row order is R, G, B. The three products of a row are summed at full precision. The sum is then rounded half-up, i.e. (sum + 256) shifted right arithmetically by 9.
- R5: An 11-bit two's-complement post-bias is added to each rounded row. The result is then limited to that output channel's window, using the same order as R2.
- R6: in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, every stage holds and the outputs do not change. No pixel is lost or duplicated.
- R7: When bit 0 of the mode register is 0, R, G and B appear unchanged on out_y, out_cb and out_cr. The mode value is captured with each pixel when it is accepted.
- R8: Without backpressure, a pixel accepted at clock edge E appears on the outputs right after edge E+2.
- R9: The register map is: address 0 is mode (bit 0 enables; other bits are ignored); addresses 1..9 hold the coefficients row-major (Y, Cb, Cr rows × R, G, B columns); 10..12 hold the pre-bias; 13..15 hold the post-bias; 16..21 hold the input lo/hi pairs per channel; 22..27 hold the output lo/hi pairs per channel. Writes to addresses 28..31 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 13 | Register write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_r | input | 10 | Red component |
| in_g | input | 10 | Green component |
| in_b | input | 10 | Blue component |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer ready |
| out_y | output | 10 | Luma or passed-through red |
| out_cb | output | 10 | Blue-difference chroma or passed-through green |
| out_cr | output | 10 | Red-difference chroma or passed-through blue |

## Verification
The conversion is driven with black and full white, which separate the post-bias from the output window. Saturated primaries exercise the negative coefficients. Single-lsb coefficients against a half-lsb input tell half-up rounding apart from truncation, and negative rounding apart from rounding toward zero. Random pixels are then applied under the default table, under narrowed input windows, under a negative pre-bias, and with narrowed output windows. Each of these patterns is applied with the consumer stalling at random, which separates correct holding from lost or repeated pixels. Bypass is tried before and after the converter is enabled, including a mode value with only the upper bits set. Writes to unmapped addresses are followed by conversions that must still match the unchanged table.

// File: rtl/rgb2yuv_csc.sv
module rgb2yuv_csc #(
  parameter int DW   = 10,
  parameter int CW   = 13,
  parameter int FRAC = 9,
  parameter int AW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_r,
  input  logic [DW-1:0] in_g,
  input  logic [DW-1:0] in_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_cb,
  output logic [DW-1:0] out_cr
);
  localparam int XW = DW + 2;
  localparam int SW = XW + CW + 2;
  localparam int BW = DW + 1;
  localparam int RW = SW - FRAC;
  localparam int OW = RW + 1;
  localparam logic [DW-1:0] MAXV = '1;
  localparam logic signed [CW-1:0] DEF_COEF [9] = '{
    CW'('h0083), CW'('h0102), CW'('h0032),
    CW'('h1FB5), CW'('h1F6C), CW'('h00E1),
    CW'('h00E1), CW'('h1F45), CW'('h1FDC)};
  localparam logic signed [BW-1:0] DEF_POST [3] = '{BW'('h040), BW'('h200), BW'('h200)};
  localparam logic [DW-1:0] DEF_OLO [3] = '{DW'('h040), DW'('h040), DW'('h040)};
  localparam logic [DW-1:0] DEF_OHI [3] = '{DW'('h3AC), DW'('h3C0), DW'('h3C0)};

  function automatic logic [DW-1:0] limit(input logic signed [OW-1:0] v,
                                          input logic [DW-1:0] lo, input logic [DW-1:0] hi);
    if (v < $signed({{(OW-DW){1'b0}}, lo})) return lo;
    if (v > $signed({{(OW-DW){1'b0}}, hi})) return hi;
    return v[DW-1:0];
  endfunction

  logic                 mode_en;
  logic signed [CW-1:0] coef [9];
  logic signed [BW-1:0] pre_b [3];
  logic signed [BW-1:0] post_b [3];
  logic [DW-1:0]        pre_lo [3];
  logic [DW-1:0]        pre_hi [3];
  logic [DW-1:0]        post_lo [3];
  logic [DW-1:0]        post_hi [3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_en <= 1'b0;
      for (int i = 0; i < 9; i++) coef[i] <= DEF_COEF[i];
      for (int c = 0; c < 3; c++) begin
        pre_b[c]   <= '0;
        post_b[c]  <= DEF_POST[c];
        pre_lo[c]  <= '0;
        pre_hi[c]  <= MAXV;
        post_lo[c] <= DEF_OLO[c];
        post_hi[c] <= DEF_OHI[c];
      end
    end else if (cfg_we) begin
      if (cfg_addr == AW'(0)) mode_en <= cfg_wdata[0];
      for (int i = 0; i < 9; i++)
        if (cfg_addr == AW'(1 + i)) coef[i] <= cfg_wdata;
      for (int c = 0; c < 3; c++) begin
        if (cfg_addr == AW'(10 + c))    pre_b[c]   <= cfg_wdata[BW-1:0];
        if (cfg_addr == AW'(13 + c))    post_b[c]  <= cfg_wdata[BW-1:0];
        if (cfg_addr == AW'(16 + 2*c))  pre_lo[c]  <= cfg_wdata[DW-1:0];
        if (cfg_addr == AW'(17 + 2*c))  pre_hi[c]  <= cfg_wdata[DW-1:0];
        if (cfg_addr == AW'(22 + 2*c))  post_lo[c] <= cfg_wdata[DW-1:0];
        if (cfg_addr == AW'(23 + 2*c))  post_hi[c] <= cfg_wdata[DW-1:0];
      end
    end

  logic                 adv, v1, v2, v3, e1, e2;
  logic [DW-1:0]        raw_in [3];
  logic [DW-1:0]        raw1 [3];
  logic [DW-1:0]        raw2 [3];
  logic signed [XW-1:0] x_nx [3];
  logic signed [XW-1:0] x1 [3];
  logic signed [SW-1:0] acc_nx [3];
  logic signed [SW-1:0] acc2 [3];
  logic signed [RW-1:0] rnd [3];
  logic signed [OW-1:0] biased [3];
  logic [DW-1:0]        res_nx [3];
  logic [DW-1:0]        res3 [3];

  assign adv       = !v3 || out_ready;
  assign in_ready  = adv;
  assign out_valid = v3;
  assign raw_in[0] = in_r;
  assign raw_in[1] = in_g;
  assign raw_in[2] = in_b;
  assign out_y     = res3[0];
  assign out_cb    = res3[1];
  assign out_cr    = res3[2];

  always_comb
    for (int c = 0; c < 3; c++) begin
      x_nx[c] = $signed({2'b00, limit(OW'(raw_in[c]), pre_lo[c], pre_hi[c])}) + XW'(pre_b[c]);
      acc_nx[c] = '0;
      for (int k = 0; k < 3; k++)
        acc_nx[c] = acc_nx[c] + SW'(x1[k]) * SW'(coef[3*c + k]);
      rnd[c]    = RW'((acc2[c] + SW'(1 << (FRAC - 1))) >>> FRAC);
      biased[c] = OW'(rnd[c]) + OW'(post_b[c]);
      res_nx[c] = e2 ? limit(biased[c], post_lo[c], post_hi[c]) : raw2[c];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {v1, v2, v3} <= '0;
    else if (adv) {v1, v2, v3} <= {in_valid, v1, v2};

  always_ff @(posedge clk)
    if (adv) begin
      e1 <= mode_en;
      e2 <= e1;
      for (int c = 0; c < 3; c++) begin
        raw1[c] <= raw_in[c];
        x1[c]   <= x_nx[c];
        raw2[c] <= raw1[c];
        acc2[c] <= acc_nx[c];
        res3[c] <= res_nx[c];
      end
    end
endmodule

// File: rtl/rgb2yuv_csc_chk.sv
module rgb2yuv_csc_chk #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_r,
  input logic [DW-1:0] in_g,
  input logic [DW-1:0] in_b,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_y,
  input logic [DW-1:0] out_cb,
  input logic [DW-1:0] out_cr,
  input logic          mode_en
);
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_y) && $stable(out_cb) && $stable(out_cr));

  p_no_accept_stalled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready ##1 out_ready ##1 out_ready |=> out_valid);

  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !mode_en ##1 out_ready ##1 out_ready |=>
      out_y == $past(in_r, 3) && out_cb == $past(in_g, 3) && out_cr == $past(in_b, 3));
endmodule

bind rgb2yuv_csc rgb2yuv_csc_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_r(in_r), .in_g(in_g), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
  .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr), .mode_en(mode_en));

// File: tb/rgb2yuv_csc_test.sv
module rgb2yuv_csc_test;
  logic clk = 0, rst_n = 0, cfg_we = 0, in_valid = 0, out_ready = 1;
  logic [4:0] cfg_addr = '0;
  logic [12:0] cfg_wdata = '0;
  logic [9:0] in_r = '0, in_g = '0, in_b = '0;
  logic in_ready, out_valid;
  logic [9:0] out_y, out_cb, out_cr;

  rgb2yuv_csc uut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready), .in_r(in_r),
    .in_g(in_g), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr));

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  bit bp_on = 0, lat_on = 0, done = 0;
  string cur_tag = "R1";
  int m_en, m_coef[9], m_preb[3], m_postb[3], m_plo[3], m_phi[3], m_olo[3], m_ohi[3];
  logic [29:0] exp_q[$];
  int acc_q[$];
  string tag_q[$];

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sx(input int v, input int w);
    v = v & ((1 << w) - 1);
    return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
  endfunction

  function automatic int lim(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic logic [29:0] model(input int r, input int g, input int b);
    int px[3], x[3], o[3], s;
    px[0] = r; px[1] = g; px[2] = b;
    if (m_en == 0) return {r[9:0], g[9:0], b[9:0]};
    for (int c = 0; c < 3; c++) x[c] = lim(px[c], m_plo[c], m_phi[c]) + m_preb[c];
    for (int c = 0; c < 3; c++) begin
      s = 0;
      for (int k = 0; k < 3; k++) s += x[k] * m_coef[3*c + k];
      o[c] = lim(((s + 256) >>> 9) + m_postb[c], m_olo[c], m_ohi[c]);
    end
    return {o[0][9:0], o[1][9:0], o[2][9:0]};
  endfunction

  task automatic model_reset();
    int dc[9] = '{'h083, 'h102, 'h032, 'h1FB5, 'h1F6C, 'h0E1, 'h0E1, 'h1F45, 'h1FDC};
    m_en = 0;
    for (int i = 0; i < 9; i++) m_coef[i] = sx(dc[i], 13);
    for (int c = 0; c < 3; c++) begin
      m_preb[c] = 0; m_plo[c] = 0; m_phi[c] = 'h3FF; m_olo[c] = 'h040;
      m_postb[c] = (c == 0) ? 'h040 : 'h200;
      m_ohi[c] = (c == 0) ? 'h3AC : 'h3C0;
    end
  endtask

  task automatic wr(input int a, input int d);
    cfg_we = 1; cfg_addr = a[4:0]; cfg_wdata = d[12:0];
    @(posedge clk); #1 cfg_we = 0;
    if (a == 0) m_en = d & 1;
    else if (a <= 9) m_coef[a-1] = sx(d, 13);
    else if (a <= 12) m_preb[a-10] = sx(d, 11);
    else if (a <= 15) m_postb[a-13] = sx(d, 11);
    else if (a <= 21) begin if ((a - 16) % 2 == 0) m_plo[(a-16)/2] = d & 'h3FF; else m_phi[(a-16)/2] = d & 'h3FF; end
    else if (a <= 27) begin if ((a - 22) % 2 == 0) m_olo[(a-22)/2] = d & 'h3FF; else m_ohi[(a-22)/2] = d & 'h3FF; end
  endtask

  task automatic send(input int r, input int g, input int b);
    bit got = 0;
    in_valid = 1; in_r = r[9:0]; in_g = g[9:0]; in_b = b[9:0];
    while (!got) begin
      @(negedge clk); got = in_ready;
      @(posedge clk); #1;
    end
    in_valid = 0;
  endtask

  task automatic send_rand(input int n);
    for (int i = 0; i < n; i++) send($urandom % 1024, $urandom % 1024, $urandom % 1024);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  always @(posedge clk) cyc++;

  initial forever begin
    @(posedge clk); #1;
    out_ready = bp_on ? (($urandom % 4) != 0) : 1'b1;
  end

  logic [29:0] e;
  int ea;
  string et;
  always @(negedge clk) if (rst_n) begin
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check("R6 unexpected output", 0, {out_y, out_cb, out_cr}, 0);
      else begin
        e = exp_q.pop_front(); ea = acc_q.pop_front(); et = tag_q.pop_front();
        check(et, {out_y, out_cb, out_cr} == e, {out_y, out_cb, out_cr}, e);
        if (lat_on) check("R8 latency", cyc - ea == 2, cyc - ea, 2);
      end
    end
    if (in_valid && in_ready) begin
      exp_q.push_back(model(in_r, in_g, in_b));
      acc_q.push_back(cyc + 1);
      tag_q.push_back(cur_tag);
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      check("WATCHDOG", 0, cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1 out_valid in reset", out_valid == 0, out_valid, 0);
    rst_n = 1;
    @(posedge clk); #1;
    check("R1 in_ready after reset", in_ready == 1, in_ready, 1);

    cur_tag = "R7 bypass"; bp_on = 1;
    send(0, 0, 0); send(1023, 512, 1); send_rand(20); drain();

    wr(0, 'h5);
    cur_tag = "R1 R5 defaults";
    send(0, 0, 0); send(1023, 1023, 1023); send(1023, 0, 0); send(0, 1023, 0); send(0, 0, 1023);
    drain();

    bp_on = 0; lat_on = 1; cur_tag = "R8";
    send_rand(6); drain(); lat_on = 0;

    bp_on = 1; cur_tag = "R6 random stall";
    send_rand(200); drain();

    cur_tag = "R9 unmapped";
    for (int a = 28; a < 32; a++) wr(a, 'h1ABC);
    send(0, 0, 0); send(1023, 1023, 1023); send_rand(20); drain();

    cur_tag = "R2 input window";
    wr(16, 'h100); wr(17, 'h300); wr(20, 'h080);
    send(0, 0, 0); send(1023, 1023, 1023); send_rand(40); drain();
    wr(16, 0); wr(17, 'h3FF); wr(20, 0);

    cur_tag = "R3 pre-bias";
    wr(10, 'h7C0); wr(11, 'h040); wr(12, 'h7FF);
    send(0, 0, 0); send_rand(40); drain();
    wr(10, 0); wr(11, 0); wr(12, 0);

    cur_tag = "R4 rounding";
    for (int a = 1; a <= 9; a++) wr(a, 0);
    wr(1, 'h001); wr(5, 'h1FFF); wr(9, 'h200);
    for (int c = 0; c < 3; c++) begin wr(13 + c, 0); wr(22 + 2*c, 0); wr(23 + 2*c, 'h3FF); end
    send(256, 256, 300); send(255, 255, 0); send(257, 257, 1023); send(768, 768, 5); send_rand(30); drain();
    wr(2, 'h1E00); wr(6, 'h0C00);
    send_rand(30); drain();

    cur_tag = "R5 output window";
    wr(13, 'h7F0); wr(22, 'h050); wr(23, 'h100); wr(25, 'h2FF);
    send(0, 0, 0); send(1023, 1023, 1023); send_rand(40); drain();

    cur_tag = "R7 R9 mode upper bits";
    wr(0, 'h6);
    send(5, 6, 7); send_rand(20); drain();

    check("R6 all outputs delivered", exp_q.size() == 0, exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule